// File: doc/BRIEF.md
# RGMII Double-Data-Rate Pin Shim

This block sits between a byte-wide transmit/receive datapath running at the 125 MHz interface rate and the reduced-pin double-data-rate pad interface of a gigabit PHY. On the transmit side it takes one byte per clock, together with an enable and an error flag. It splits the byte into two nibbles, driving the low nibble while the clock is high and the high nibble while it is low. The control pad carries the enable in the high phase and the exclusive-or of enable and error in the low phase. The falling-phase output registers are clocked on the inverted clock. A forwarded clock leaves the block a quarter period late, so the PHY sees each clock edge centred in the data eye.

On the receive side the pads are sampled on both edges of the receive clock. The nibble and control bit taken on the rising edge, and the pair taken on the following falling edge, are joined back into a byte, a valid flag and an error flag. These are registered on the next rising edge. Clock generation and its phase shift come from outside: the block receives both the interface clock and its quarter-period-delayed copy. The double-rate pad registers are modelled behaviourally.

Top module: `rgmii_ddr_shim`

## Requirements
- R1: The upper pins `pad_txd[7:4]` are driven to zero at all times.
- R2: A byte presented on `tx_data` before a rising edge of `clk` appears on `pad_txd[3:0]` as its bits [3:0] while `clk` is high after that edge, and as its bits [7:4] while `clk` is low in the same cycle.
- R3: `pad_tx_ctl` equals the captured `tx_en` while `clk` is high, and equals `tx_en XOR tx_err` while `clk` is low in the same cycle.
- R4: Once out of reset, `pad_tx_clk` follows `clk90` and so lags `clk` by a quarter period. It is low at each rising edge of `clk`, high at each falling edge, and high again a quarter period after each rising edge.
- R5: The nibble on `pad_rxd` taken at a rising edge of `rx_clk` becomes `rx_data[3:0]`, and the nibble taken at the following falling edge becomes `rx_data[7:4]`. Both appear together after the next rising edge.
- R6: `rx_dv` equals the control pad value sampled at the rising edge. `rx_er` equals the rising-edge control value XOR the falling-edge control value. Both have the same timing as `rx_data`.
- R7: While `rst` is high at clock edges, every pad output and every receive output is driven low, including `pad_tx_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, also the transmit clock |
| clk90 | input | 1 | Copy of `clk` delayed by a quarter period, used for the forwarded clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 8 | Byte to transmit this cycle |
| tx_en | input | 1 | Transmit enable for this byte |
| tx_err | input | 1 | Transmit error flag for this byte |
| pad_txd | output | 8 | Transmit data pins; bits [3:0] double rate, bits [7:4] zero |
| pad_tx_ctl | output | 1 | Double-rate transmit control pin |
| pad_tx_clk | output | 1 | Forwarded transmit clock, a quarter period late |
| rx_clk | input | 1 | Receive clock from the PHY |
| pad_rxd | input | 4 | Double-rate receive data pins |
| pad_rx_ctl | input | 1 | Double-rate receive control pin |
| rx_data | output | 8 | Reassembled receive byte |
| rx_dv | output | 1 | Receive valid |
| rx_er | output | 1 | Receive error |

## Verification
The hardest situation to create is a pair of halves that differ within a single clock cycle, where the pad value changes between the rising and the falling edge. Only then can a swapped nibble order or a wrong control decode be seen. The stimulus therefore moves the receive pads twice per cycle, once in each clock phase and clear of both edges. It samples the transmit pads once in each phase, using bytes whose two nibbles differ, such as 0xA5 and 0x3C. All four enable/error combinations are covered, including error with enable low. The quarter-period lag of the forwarded clock is observed by sampling the pin half a nanosecond on either side of the delayed edge.

// File: rtl/rgmii_shim_pkg.sv
`timescale 1ns/1ps
package rgmii_shim_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int HALF_W = NIB_W + 1;

    // One pad-side half cycle: a nibble plus the control bit
    typedef struct packed {
        logic             ctl;
        logic [NIB_W-1:0] nib;
    } rg_half_t;

    // Both halves of one clock cycle
    typedef struct packed {
        rg_half_t rise;
        rg_half_t fall;
    } rg_pair_t;

    // One byte-wide beat on the internal side
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              en;
        logic              err;
    } gm_beat_t;

    function automatic rg_pair_t encode_beat(gm_beat_t b);
        rg_pair_t p;
        p.rise.nib = b.data[NIB_W-1:0];
        p.rise.ctl = b.en;
        p.fall.nib = b.data[BYTE_W-1:NIB_W];
        p.fall.ctl = b.en ^ b.err;
        return p;
    endfunction

    function automatic gm_beat_t decode_pair(rg_pair_t p);
        gm_beat_t b;
        b.data = {p.fall.nib, p.rise.nib};
        b.en   = p.rise.ctl;
        b.err  = p.rise.ctl ^ p.fall.ctl;
        return b;
    endfunction

endpackage

// File: rtl/rgmii_oddr.sv
`timescale 1ns/1ps
// Behavioural double-rate output cell: d_rise is shown while clk is high,
// d_fall while clk is low. The falling value is moved on the inverted clock.
module rgmii_oddr (
    input  logic clk,
    input  logic rst,
    input  logic d_rise,
    input  logic d_fall,
    output logic q
);
    logic rise_q;
    logic hold_q;
    logic fall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            rise_q <= d_rise;
            hold_q <= d_fall;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) fall_q <= 1'b0;
        else     fall_q <= hold_q;
    end

    assign q = clk ? rise_q : fall_q;

    // R2 R3
    oddr_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rise_q == $past(d_rise));

endmodule

// File: rtl/rgmii_iddr.sv
`timescale 1ns/1ps
// Behavioural double-rate input cell: one sample per clock edge.
module rgmii_iddr (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q_rise,
    output logic q_fall
);
    always_ff @(posedge clk) begin
        if (rst) q_rise <= 1'b0;
        else     q_rise <= d;
    end

    always_ff @(negedge clk) begin
        if (rst) q_fall <= 1'b0;
        else     q_fall <= d;
    end
endmodule

// File: rtl/rgmii_tx_path.sv
`timescale 1ns/1ps
module rgmii_tx_path
    import rgmii_shim_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  gm_beat_t beat_i,
    output rg_half_t pin_o
);
    rg_pair_t          pair;
    logic [HALF_W-1:0] rise_bits;
    logic [HALF_W-1:0] fall_bits;
    logic [HALF_W-1:0] pin_bits;

    assign pair      = encode_beat(beat_i);
    assign rise_bits = pair.rise;
    assign fall_bits = pair.fall;

    for (genvar i = 0; i < HALF_W; i++) begin : g_bit
        rgmii_oddr u_oddr (
            .clk    (clk),
            .rst    (rst),
            .d_rise (rise_bits[i]),
            .d_fall (fall_bits[i]),
            .q      (pin_bits[i])
        );
    end

    assign pin_o = pin_bits;
endmodule

// File: rtl/rgmii_rx_path.sv
`timescale 1ns/1ps
module rgmii_rx_path
    import rgmii_shim_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rg_half_t pin_i,
    output gm_beat_t beat_o
);
    logic [HALF_W-1:0] pin_bits;
    logic [HALF_W-1:0] rise_bits;
    logic [HALF_W-1:0] fall_bits;
    rg_pair_t          pair;

    assign pin_bits = pin_i;

    for (genvar i = 0; i < HALF_W; i++) begin : g_bit
        rgmii_iddr u_iddr (
            .clk    (clk),
            .rst    (rst),
            .d      (pin_bits[i]),
            .q_rise (rise_bits[i]),
            .q_fall (fall_bits[i])
        );
    end

    assign pair = {rise_bits, fall_bits};

    always_ff @(posedge clk) begin
        if (rst) beat_o <= '0;
        else     beat_o <= decode_pair(pair);
    end

    // R6
    rx_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> beat_o.en == $past(pin_i.ctl, 2));

    // R5
    rx_low_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> beat_o.data[NIB_W-1:0] == $past(pin_i.nib, 2));

endmodule

// File: rtl/rgmii_ddr_shim.sv
`timescale 1ns/1ps
module rgmii_ddr_shim
    import rgmii_shim_pkg::*;
#(
    parameter int TXD_PINS = 8
) (
    input  logic                clk,
    input  logic                clk90,
    input  logic                rst,
    input  logic [BYTE_W-1:0]   tx_data,
    input  logic                tx_en,
    input  logic                tx_err,
    output logic [TXD_PINS-1:0] pad_txd,
    output logic                pad_tx_ctl,
    output logic                pad_tx_clk,
    input  logic                rx_clk,
    input  logic [NIB_W-1:0]    pad_rxd,
    input  logic                pad_rx_ctl,
    output logic [BYTE_W-1:0]   rx_data,
    output logic                rx_dv,
    output logic                rx_er
);
    localparam int PAD_W = TXD_PINS - NIB_W;

    gm_beat_t tx_beat;
    rg_half_t tx_half;
    rg_half_t rx_half;
    gm_beat_t rx_beat;

    assign tx_beat = '{data: tx_data, en: tx_en, err: tx_err};

    rgmii_tx_path u_tx (
        .clk    (clk),
        .rst    (rst),
        .beat_i (tx_beat),
        .pin_o  (tx_half)
    );

    if (PAD_W > 0) begin : g_pad
        assign pad_txd = {{PAD_W{1'b0}}, tx_half.nib};
    end else begin : g_nopad
        assign pad_txd = tx_half.nib;
    end
    assign pad_tx_ctl = tx_half.ctl;

    // Forwarded clock: constant 1/0 through a double-rate cell on the delayed clock
    rgmii_oddr u_fwd (
        .clk    (clk90),
        .rst    (rst),
        .d_rise (1'b1),
        .d_fall (1'b0),
        .q      (pad_tx_clk)
    );

    assign rx_half = '{ctl: pad_rx_ctl, nib: pad_rxd};

    rgmii_rx_path u_rx (
        .clk    (rx_clk),
        .rst    (rst),
        .pin_i  (rx_half),
        .beat_o (rx_beat)
    );

    assign rx_data = rx_beat.data;
    assign rx_dv   = rx_beat.en;
    assign rx_er   = rx_beat.err;

    // R4
    fwd_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pad_tx_clk == 1'b0);

    // R4
    fwd_clk_high_chk: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> pad_tx_clk == 1'b1);

endmodule

// File: tb/rgmii_ddr_shim_tb.sv
`timescale 1ns/1ps
module rgmii_ddr_shim_tb_top;

    typedef struct {
        logic [7:0] data;
        logic       en;
        logic       err;
    } item_t;

    logic       clk = 1'b0;
    logic       clk90 = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] tx_data = '0;
    logic       tx_en = 1'b0;
    logic       tx_err = 1'b0;
    logic [7:0] pad_txd;
    logic       pad_tx_ctl;
    logic       pad_tx_clk;
    logic [3:0] pad_rxd = '0;
    logic       pad_rx_ctl = 1'b0;
    logic [7:0] rx_data;
    logic       rx_dv;
    logic       rx_er;

    int total = 0;
    int bad = 0;
    item_t txq[$];
    item_t rxq[$];

    always #2 clk = ~clk;  // 250 MHz
    always @(posedge clk) #1 clk90 = 1'b1;
    always @(negedge clk) #1 clk90 = 1'b0;

    rgmii_ddr_shim dut_i (
        .clk        (clk),
        .clk90      (clk90),
        .rst        (rst),
        .tx_data    (tx_data),
        .tx_en      (tx_en),
        .tx_err     (tx_err),
        .pad_txd    (pad_txd),
        .pad_tx_ctl (pad_tx_ctl),
        .pad_tx_clk (pad_tx_clk),
        .rx_clk     (clk),
        .pad_rxd    (pad_rxd),
        .pad_rx_ctl (pad_rx_ctl),
        .rx_data    (rx_data),
        .rx_dv      (rx_dv),
        .rx_er      (rx_er)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tx_send(input logic [7:0] d, input logic en, input logic err);
        @(negedge clk);
        tx_data = d; tx_en = en; tx_err = err;
        txq.push_back('{data: d, en: en, err: err});
    endtask

    task automatic rx_send(input logic [7:0] d, input logic vld, input logic err);
        @(negedge clk);
        #1;
        pad_rxd = d[3:0]; pad_rx_ctl = vld;
        @(posedge clk);
        #1;
        pad_rxd = d[7:4]; pad_rx_ctl = vld ^ err;
        rxq.push_back('{data: d, en: vld, err: err});
    endtask

    // Transmit monitor: one sample in each phase
    always begin
        logic [3:0] lo, hi, up_a, up_b;
        logic cr, cf;
        @(posedge clk); #1;
        lo = pad_txd[3:0]; cr = pad_tx_ctl; up_a = pad_txd[7:4];
        @(negedge clk); #1;
        hi = pad_txd[3:0]; cf = pad_tx_ctl; up_b = pad_txd[7:4];
        if (!rst && txq.size() >= 2) begin
            item_t e;
            e = txq.pop_front();
            check("R1 upper pins high phase", 32'(up_a), 32'(0));
            check("R1 upper pins low phase", 32'(up_b), 32'(0));
            check("R2 low nibble in high phase", 32'(lo), 32'(e.data[3:0]));
            check("R2 high nibble in low phase", 32'(hi), 32'(e.data[7:4]));
            check("R3 ctl high phase = en", 32'(cr), 32'(e.en));
            check("R3 ctl low phase = en^err", 32'(cf), 32'(e.en ^ e.err));
        end
    end

    // Receive monitor
    always begin
        @(posedge clk); #2;
        if (!rst && rxq.size() >= 2) begin
            item_t e;
            e = rxq.pop_front();
            check("R5 rx byte", 32'(rx_data), 32'(e.data));
            check("R6 rx valid", 32'(rx_dv), 32'(e.en));
            check("R6 rx error", 32'(rx_er), 32'(e.err));
        end
    end

    task automatic finish_up;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        // R7: reset state while inputs are busy
        tx_data = 8'hFF; tx_en = 1'b1; tx_err = 1'b1;
        pad_rxd = 4'hF; pad_rx_ctl = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R7 txd high phase", 32'(pad_txd), 32'(0));
        check("R7 tx ctl high phase", 32'(pad_tx_ctl), 32'(0));
        check("R7 rx outputs", 32'({rx_data, rx_dv, rx_er}), 32'(0));
        @(negedge clk); #1;
        check("R7 txd low phase", 32'(pad_txd), 32'(0));
        check("R7 tx ctl low phase", 32'(pad_tx_ctl), 32'(0));
        check("R7 forwarded clock held", 32'(pad_tx_clk), 32'(0));
        @(negedge clk);
        tx_data = '0; tx_en = 1'b0; tx_err = 1'b0;
        pad_rxd = '0; pad_rx_ctl = 1'b0;
        rst = 1'b0;

        // R4: forwarded clock phase
        repeat (3) @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #0.5;
            check("R4 fwd clk low just after rising edge", 32'(pad_tx_clk), 32'(0));
            #1;
            check("R4 fwd clk high a quarter period later", 32'(pad_tx_clk), 32'(1));
            @(negedge clk); #0.5;
            check("R4 fwd clk high at falling edge", 32'(pad_tx_clk), 32'(1));
            #1;
            check("R4 fwd clk low after delayed fall", 32'(pad_tx_clk), 32'(0));
        end

        // Transmit patterns (R1 R2 R3)
        tx_send(8'hA5, 1'b1, 1'b0);
        tx_send(8'h3C, 1'b1, 1'b0);
        tx_send(8'hFF, 1'b1, 1'b1);
        tx_send(8'h00, 1'b1, 1'b1);
        tx_send(8'h0F, 1'b0, 1'b1);
        tx_send(8'hF0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++)
            tx_send(8'((i * 37) ^ 8'h5A), i[0], i[1]);
        tx_send(8'h00, 1'b0, 1'b0);
        tx_send(8'h00, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        txq.delete();

        // Receive patterns (R5 R6)
        rx_send(8'hA5, 1'b1, 1'b0);
        rx_send(8'h3C, 1'b1, 1'b0);
        rx_send(8'hC3, 1'b1, 1'b1);
        rx_send(8'h5A, 1'b0, 1'b1);
        rx_send(8'hF0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++)
            rx_send(8'((i * 53) ^ 8'h96), i[1], i[0]);
        rx_send(8'h00, 1'b0, 1'b0);
        rx_send(8'h00, 1'b0, 1'b0);
        repeat (4) @(posedge clk);

        finish_up();
    end

endmodule